// File: doc/BRIEF.md
# Sixteen-Source Priority Interrupt Controller

The controller merges sixteen interrupt sources into a single request line for a processor core. Half of the sources are external pins that are sensed on a falling edge and held in a latch until software acknowledges them. The other half are internal level signals that show up in the pending view for as long as they are asserted. The two kinds alternate in one fixed priority chain, so each pin outranks the level source that follows it.

Software reaches the controller through three word-sized registers on a simple read/write bus. The first shows pending sources, and a write of ones to it acknowledges pin latches. The second is a freely writable enable mask. The third is a read-only vector that names the highest-priority source that is both pending and enabled. A service routine typically reads the vector and narrows the mask to block sources of equal or lower priority. It then acknowledges the pin and restores the mask when it is done.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source index i runs from 0 (highest priority) to 15. An even i is pin i/2, an odd i is level source (i-1)/2, and source i sits at bit 31-i of both the pending register (word offset 0) and the mask register (word offset 1).
- R2: A high-to-low transition on a pin, seen between two consecutive rising clock edges, sets that pin's pending bit at the second edge. The bit stays set after the pin returns high.
- R3: A level source's pending bit follows its input directly, with no clock delay and no latching.
- R4: A write to the pending register clears every pin latch whose bit is written as one. Ones written to level-source bits have no effect, and zeros have no effect.
- R5: Bits 31:16 of the mask register read back the last value written to them.
- R6: irq_o is high exactly when some bit of pending AND mask is set.
- R7: The vector register (word offset 2) holds the index of the lowest-numbered source that is both pending and masked-in in bits 31:26, with all other bits zero.
- R8: When no source is both pending and masked-in, the vector register reads 0 and irq_o is low.
- R9: After reset the mask is all zeros and every pin latch is clear.
- R10: Bits 15:0 of pending, mask and vector always read zero, and writes to them have no effect.
- R11: If a falling edge and an acknowledge of the same pin hit the same clock edge, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word offset: 0 pending, 1 mask, 2 vector |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pin_i | input | 8 | External sources, falling-edge sensitive |
| lvl_i | input | 8 | Internal sources, active-high level |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The tests are built around the fact that each piece of state shows up at the ports on the next cycle. A stuck or missed edge latch is visible in the pending word and in irq_o one clock after the edge. A latch that clears wrongly shows up in the same read that follows the acknowledge. An error in the priority chain or in the bit mapping appears at once in the vector word whenever two enabled sources are pending together. Masking is checked by reading irq_o back with the same pending state and the mask set to different values.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NUM_PINS = 8;
  localparam int unsigned NSRC     = 2 * NUM_PINS;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = $clog2(NSRC);
  localparam int unsigned VEC_W    = 6;

  typedef enum logic [1:0] {
    OFS_PEND = 2'd0,
    OFS_MASK = 2'd1,
    OFS_VEC  = 2'd2
  } reg_ofs_e;
endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] fall;

  assign fall = prev_q & ~pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      pend_o <= '0;
    end else begin
      prev_q <= pin_i;
      pend_o <= (pend_o & ~clr_i) | fall;  // set wins over acknowledge
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall[k] |=> pend_o[k]);  // R2
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !fall[k]) |=> !pend_o[k]);  // R4
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        idx_o   = IDX_W'(k);
        valid_o = 1'b1;
      end
    end
  end

  logic [N-1:0] higher;
  assign higher = (N'(1) << idx_o) - N'(1);

  AST_NO_HIGHER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((req_i & higher) == '0) && req_i[idx_o]);  // R1
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  output logic                irq_o
);
  localparam int unsigned TOP = DATA_W - 1;
  localparam int unsigned LOW = DATA_W - NSRC;

  logic [NSRC-1:0]     mask_q;
  logic [NUM_PINS-1:0] pin_pend;
  logic [NUM_PINS-1:0] pin_clr;
  logic [NSRC-1:0]     pend_fld;  // bit position within 31:16 field
  logic [NSRC-1:0]     req;       // indexed by priority
  logic [IDX_W-1:0]    win_idx;
  logic                win_vld;
  logic [DATA_W-1:0]   pend_word, mask_word, vec_word;
  logic                unused_wdata;

  assign unused_wdata = ^wdata_i[LOW-1:0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    assign pin_clr[p] = we_i && (addr_i == OFS_PEND) && wdata_i[TOP - 2*p];
    assign pend_fld[NSRC-1 - 2*p]     = pin_pend[p];
    assign pend_fld[NSRC-1 - (2*p+1)] = lvl_i[p];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_req
    assign req[i] = pend_fld[NSRC-1 - i] & mask_q[NSRC-1 - i];
  end

  pic_edge_latch #(.N(NUM_PINS)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .clr_i  (pin_clr),
    .pend_o (pin_pend)
  );

  pic_prio_enc #(.N(NSRC), .IDX_W(IDX_W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .idx_o   (win_idx),
    .valid_o (win_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            mask_q <= '0;
    else if (we_i && addr_i == OFS_MASK)    mask_q <= wdata_i[TOP:LOW];
  end

  assign pend_word = {pend_fld, {LOW{1'b0}}};
  assign mask_word = {mask_q, {LOW{1'b0}}};
  assign vec_word  = win_vld ? {VEC_W'(win_idx), {(DATA_W-VEC_W){1'b0}}} : '0;
  assign irq_o     = |(pend_word & mask_word);

  always_comb begin
    unique case (addr_i)
      OFS_PEND: rdata_o = pend_word;
      OFS_MASK: rdata_o = mask_word;
      OFS_VEC:  rdata_o = vec_word;
      default:  rdata_o = '0;
    endcase
  end

  AST_MASK_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_MASK) |=> mask_word[TOP:LOW] == $past(wdata_i[TOP:LOW]));  // R5
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_word == '0));  // R8
  AST_IRQ_HAS_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_word[TOP - win_idx] && mask_word[TOP - win_idx]));  // R7
  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[LOW-1:0] == '0);  // R10
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin = 8'hFF;
  logic [7:0]  lvl = 8'h00;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .lvl_i(lvl), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic fall_pin(input int p);
    @(negedge clk);
    pin[p] = 1'b0;
    @(negedge clk);
    pin[p] = 1'b1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd1, v); chk("R9 mask after reset", v, 32'h0);
    rd(2'd0, v); chk("R9 pending after reset", v, 32'h0);
    rd(2'd2, v); chk("R8 vector idle", v, 32'h0);
    chk("R8 irq idle", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(2'd1, 32'hA5A5_FFFF);
    rd(2'd1, v); chk("R5 R10 mask readback", v, 32'hA5A5_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R5 mask all", v, 32'hFFFF_0000);
  endtask

  task automatic t_level_and_pin;
    logic [31:0] v;
    @(negedge clk); lvl[2] = 1'b1;  // source 5, bit 26
    rd(2'd0, v); chk("R3 level direct", v, 32'h0400_0000);
    rd(2'd2, v); chk("R7 vector level2", v, 32'h1400_0000);
    chk("R6 irq with level", {31'b0, irq}, 32'h1);
    fall_pin(3);                    // source 6, bit 25
    rd(2'd0, v); chk("R2 pin3 latched", v, 32'h0600_0000);
    rd(2'd2, v); chk("R1 level2 outranks pin3", v, 32'h1400_0000);
    wr(2'd1, 32'hFBFF_0000);
    rd(2'd2, v); chk("R7 vector pin3 after mask", v, 32'h1800_0000);
    wr(2'd0, 32'h0600_FFFF);
    rd(2'd0, v); chk("R4 ack clears pin not level", v, 32'h0400_0000);
    @(negedge clk); lvl[2] = 1'b0;
    rd(2'd0, v); chk("R3 level drop", v, 32'h0);
    rd(2'd2, v); chk("R8 vector zero", v, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_0000);
    @(negedge clk); pin[0] = 1'b0; pin[7] = 1'b0;  // sources 0 and 14
    @(negedge clk);
    rd(2'd0, v); chk("R1 pin0 pin7 bits", v, 32'h8002_0000);
    rd(2'd2, v); chk("R1 pin0 wins index 0", v, 32'h0);
    chk("R6 irq with index 0", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h8000_0000);
    rd(2'd2, v); chk("R7 pin7 index 14", v, 32'h3800_0000);
    wr(2'd1, 32'h0);
    chk("R6 masked no irq", {31'b0, irq}, 32'h0);
    rd(2'd2, v); chk("R8 masked vector zero", v, 32'h0);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, v); chk("R4 zero write no effect", v, 32'h0002_0000);
    wr(2'd0, 32'h0002_0000);
    rd(2'd0, v); chk("R4 pin7 cleared", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk); pin[0] = 1'b1; pin[7] = 1'b1;
    @(negedge clk);
    pin[0] = 1'b0; we = 1'b1; addr = 2'd0; wdata = 32'h8000_0000;
    @(negedge clk); we = 1'b0;
    rd(2'd0, v); chk("R11 set beats ack", v, 32'h8000_0000);
    pin[0] = 1'b1;
    wr(2'd0, 32'h8000_0000);
    rd(2'd0, v); chk("R4 final clear", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_level_and_pin();
    t_priority();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule